// File: doc/BRIEF.md
# Lock Indication and Monitor Pin Selector

This block feeds one shared monitor pin of a two-channel frequency synthesizer. Each channel supplies its phase-comparator up and down pulses, a one-cycle strobe marking each phase-comparison event, and the terminal pulses of its reference divider and its programmable divider. From the comparator pulses the block works out whether each channel is locked. It uses a programmable pulse-width limit and a programmable count of clean comparisons.

Four latched select bits pick what the pin shows. The choices are the lock state of one channel, the combined lock state of both, a raw divider pulse routed out for test, or nothing. Three test codes also assert a counter-reset request for one channel or both. The pin and the reset requests are registered outputs.

Top module: `lock_monitor_sel`

## Requirements
- R1: While reset is asserted, and for the first cycles after it, `mon_pin`, `cnt_rst` and `chan_locked` are all 0.
- R2: The select code is {sel_fo1, sel_fo2, sel_ld1, sel_ld2}. Code 0000 drives the pin low, and so does the unlisted code 1100.
- R3: Code 0001 shows the lock output of channel 2, and code 0010 shows the lock output of channel 1.
- R4: Code 0011 shows the AND of the lock outputs of both channels.
- R5: Codes 0100 and 0110 show the channel 2 reference divider pulse. Codes 1000 and 1010 show the channel 1 reference divider pulse.
- R6: Codes 0101 and 0111 show the channel 2 programmable divider pulse. Codes 1001 and 1011 show the channel 1 programmable divider pulse.
- R7: The three counter-reset codes set bits of `cnt_rst` as follows, and in each of them the pin is low:
  - code 1101 sets `cnt_rst` = 10, meaning bit 1 for channel 2;
  - code 1110 sets `cnt_rst` = 01, meaning bit 0 for channel 1;
  - code 1111 sets `cnt_rst` = 11.
  Every other code gives `cnt_rst` = 00.
- R8: A channel becomes locked after `lock_count` comparison events (at least one) with no over-long pulse since the last clear. `chan_locked` rises on the edge that samples that event and stays high until an over-long pulse.
- R9: An up or down pulse is over-long in its (`pw_limit`+1)-th consecutive high cycle. That cycle clears the lock and the event count, so `chan_locked` is low on the next cycle. When an over-long pulse and an event fall in the same cycle, the clear wins.
- R10: A locked channel's lock output is high except in the cycles where that channel's comparison strobe is high, where it is low. An unlocked channel's lock output is low.
- R11: `mon_pin` and `cnt_rst` follow the inputs sampled on the previous rising edge, which gives one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_fo1 | input | 1 | Select bit 3: frequency-out, channel 1 |
| sel_fo2 | input | 1 | Select bit 2: frequency-out, channel 2 |
| sel_ld1 | input | 1 | Select bit 1: lock-detect, channel 1 |
| sel_ld2 | input | 1 | Select bit 0: lock-detect, channel 2 |
| pw_limit | input | PW_W | Longest allowed comparator pulse, in cycles |
| lock_count | input | LK_W | Clean comparisons needed for lock |
| pd_up | input | 2 | Comparator up pulses (bit 0 = channel 1) |
| pd_dn | input | 2 | Comparator down pulses |
| cmp_evt | input | 2 | One-cycle comparison event strobes |
| ref_div | input | 2 | Reference divider terminal pulses |
| prg_div | input | 2 | Programmable divider terminal pulses |
| mon_pin | output | 1 | Shared monitor pin |
| cnt_rst | output | 2 | Counter reset requests (bit 0 = channel 1) |
| chan_locked | output | 2 | Per-channel lock state |

## Verification
The assertions take it for granted that `pw_limit` and `lock_count` are held steady while pulses are being judged. They also assume that `lock_count` is at least one, so that a lock can only appear on a comparison event. The bench sets both values only while the comparator inputs are idle, and keeps `lock_count` non-zero. The select bits may change on any cycle. The bench changes them freely, with comparator pulses running, to test that the pin follows the new code after one register stage.

// File: rtl/lkmon_pkg.sv
package lkmon_pkg;
  localparam int NCH = 2;
  typedef logic [3:0] sel_t;          // {fo1, fo2, ld1, ld2}
  localparam sel_t SEL_OFF  = 4'b0000;
  localparam sel_t SEL_LK2  = 4'b0001;
  localparam sel_t SEL_LK1  = 4'b0010;
  localparam sel_t SEL_LKB  = 4'b0011;
  localparam sel_t SEL_TR2  = 4'b1101;
  localparam sel_t SEL_TR1  = 4'b1110;
  localparam sel_t SEL_TRB  = 4'b1111;
endpackage

// File: rtl/lkmon_rst_sync.sv
module lkmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/lkmon_lock_det.sv
module lkmon_lock_det #(
  parameter int PW_W = 8,
  parameter int LK_W = 6
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            up_i,
  input  logic            dn_i,
  input  logic            evt_i,
  input  logic [PW_W-1:0] pw_limit_i,
  input  logic [LK_W-1:0] lock_count_i,
  output logic            locked_o,
  output logic            lk_out_o
);
  localparam logic [PW_W-1:0] PW_MAX = {PW_W{1'b1}};

  logic [PW_W-1:0] up_cnt_q, up_cnt_d;
  logic [PW_W-1:0] dn_cnt_q, dn_cnt_d;
  logic [LK_W-1:0] good_q, good_d;
  logic            locked_q, locked_d;
  logic            up_long, dn_long, too_long;

  // pulse width watch
  always_comb begin
    up_long  = up_i && (up_cnt_q >= pw_limit_i);
    dn_long  = dn_i && (dn_cnt_q >= pw_limit_i);
    too_long = up_long || dn_long;
    up_cnt_d = '0;
    dn_cnt_d = '0;
    if (up_i) up_cnt_d = (up_cnt_q == PW_MAX) ? PW_MAX : up_cnt_q + PW_W'(1);
    if (dn_i) dn_cnt_d = (dn_cnt_q == PW_MAX) ? PW_MAX : dn_cnt_q + PW_W'(1);
  end

  // clean-comparison count and lock state
  always_comb begin
    good_d   = good_q;
    locked_d = locked_q;
    if (too_long) begin
      good_d   = '0;
      locked_d = 1'b0;
    end else if (evt_i) begin
      if (good_q < lock_count_i) good_d = good_q + LK_W'(1);
      if (good_d >= lock_count_i) locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      up_cnt_q <= '0;
      dn_cnt_q <= '0;
      good_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      up_cnt_q <= up_cnt_d;
      dn_cnt_q <= dn_cnt_d;
      good_q   <= good_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;
  assign lk_out_o = locked_q & ~evt_i;

  AST_LONG_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    too_long |=> !locked_q);                                   // R9
  AST_LOCK_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(locked_q) |-> $past(evt_i));                         // R8
endmodule

// File: rtl/lkmon_pin_sel.sv
module lkmon_pin_sel
  import lkmon_pkg::*;
(
  input  logic           clk,
  input  logic           rst_sn,
  input  sel_t           sel_i,
  input  logic [NCH-1:0] lk_i,
  input  logic [NCH-1:0] ref_i,
  input  logic [NCH-1:0] prg_i,
  output logic           pin_o,
  output logic [NCH-1:0] cnt_rst_o
);
  logic           pin_d;
  logic [NCH-1:0] rst_d;

  always_comb begin
    pin_d = 1'b0;
    rst_d = '0;
    casez (sel_i)
      SEL_OFF: pin_d = 1'b0;
      SEL_LK2: pin_d = lk_i[1];
      SEL_LK1: pin_d = lk_i[0];
      SEL_LKB: pin_d = lk_i[0] & lk_i[1];
      4'b01?0: pin_d = ref_i[1];
      4'b10?0: pin_d = ref_i[0];
      4'b01?1: pin_d = prg_i[1];
      4'b10?1: pin_d = prg_i[0];
      SEL_TR2: rst_d = 2'b10;
      SEL_TR1: rst_d = 2'b01;
      SEL_TRB: rst_d = 2'b11;
      default: pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pin_o     <= 1'b0;
      cnt_rst_o <= '0;
    end else begin
      pin_o     <= pin_d;
      cnt_rst_o <= rst_d;
    end
  end

  AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!rst_sn)
    (sel_i == SEL_OFF) |=> !pin_o);                            // R2
  AST_LOCK_GATES_PIN: assert property (@(posedge clk) disable iff (!rst_sn)
    (sel_i == SEL_LK1 && !lk_i[0]) |=> !pin_o);                // R3
  AST_TEST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt_rst_o != '0) |-> !pin_o);                             // R7
  AST_RST_ONLY_TEST: assert property (@(posedge clk) disable iff (!rst_sn)
    (sel_i[3:2] != 2'b11) |=> (cnt_rst_o == '0));              // R7
endmodule

// File: rtl/lock_monitor_sel.sv
module lock_monitor_sel
  import lkmon_pkg::*;
#(
  parameter int PW_W = 8,
  parameter int LK_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_fo1,
  input  logic            sel_fo2,
  input  logic            sel_ld1,
  input  logic            sel_ld2,
  input  logic [PW_W-1:0] pw_limit,
  input  logic [LK_W-1:0] lock_count,
  input  logic [1:0]      pd_up,
  input  logic [1:0]      pd_dn,
  input  logic [1:0]      cmp_evt,
  input  logic [1:0]      ref_div,
  input  logic [1:0]      prg_div,
  output logic            mon_pin,
  output logic [1:0]      cnt_rst,
  output logic [1:0]      chan_locked
);
  logic           rst_sn;
  logic [NCH-1:0] lk_out;
  sel_t           sel;

  assign sel = {sel_fo1, sel_fo2, sel_ld1, sel_ld2};

  lkmon_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lkmon_lock_det #(.PW_W(PW_W), .LK_W(LK_W)) i_lock_det (
      .clk          (clk),
      .rst_sn       (rst_sn),
      .up_i         (pd_up[c]),
      .dn_i         (pd_dn[c]),
      .evt_i        (cmp_evt[c]),
      .pw_limit_i   (pw_limit),
      .lock_count_i (lock_count),
      .locked_o     (chan_locked[c]),
      .lk_out_o     (lk_out[c])
    );
  end

  lkmon_pin_sel i_pin_sel (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .sel_i     (sel),
    .lk_i      (lk_out),
    .ref_i     (ref_div),
    .prg_i     (prg_div),
    .pin_o     (mon_pin),
    .cnt_rst_o (cnt_rst)
  );
endmodule

// File: tb/test_lock_monitor_sel.sv
module test_lock_monitor_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel = 4'b0000;
  logic [7:0] pw_limit = 8'd3;
  logic [5:0] lock_count = 6'd4;
  logic [1:0] pd_up = '0, pd_dn = '0, cmp_evt = '0, ref_div = '0, prg_div = '0;
  logic       mon_pin;
  logic [1:0] cnt_rst, chan_locked;

  int n_chk = 0, n_fail = 0;
  int up_run[2], dn_run[2], good[2];
  bit mlock[2];
  bit exp_pin;
  logic [1:0] exp_rst;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lock_monitor_sel i_lock_monitor_sel (
    .clk(clk), .rst_n(rst_n),
    .sel_fo1(sel[3]), .sel_fo2(sel[2]), .sel_ld1(sel[1]), .sel_ld2(sel[0]),
    .pw_limit(pw_limit), .lock_count(lock_count),
    .pd_up(pd_up), .pd_dn(pd_dn), .cmp_evt(cmp_evt),
    .ref_div(ref_div), .prg_div(prg_div),
    .mon_pin(mon_pin), .cnt_rst(cnt_rst), .chan_locked(chan_locked));

  function automatic string tag_of(logic [3:0] s);
    int v = s;
    if (v == 0 || v == 12) return "R2";
    if (v == 1 || v == 2)  return "R3";
    if (v == 3)            return "R4";
    if (v >= 13)           return "R7";
    if (s[0] == 1'b0)      return "R5";
    return "R6";
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // one clock: inputs are already set; predict, advance, compare (R11 latency)
  task automatic tick();
    bit lk[2];
    int v = sel;
    for (int c = 0; c < 2; c++) lk[c] = mlock[c] && !cmp_evt[c];   // R10
    exp_rst = 2'b00;
    exp_pin = 0;
    if (v == 1) exp_pin = lk[1];
    else if (v == 2) exp_pin = lk[0];
    else if (v == 3) exp_pin = lk[0] && lk[1];
    else if (v == 4 || v == 6) exp_pin = ref_div[1];
    else if (v == 8 || v == 10) exp_pin = ref_div[0];
    else if (v == 5 || v == 7) exp_pin = prg_div[1];
    else if (v == 9 || v == 11) exp_pin = prg_div[0];
    else if (v == 13) exp_rst = 2'b10;
    else if (v == 14) exp_rst = 2'b01;
    else if (v == 15) exp_rst = 2'b11;
    for (int c = 0; c < 2; c++) begin
      bit bad = (pd_up[c] && up_run[c] >= pw_limit) || (pd_dn[c] && dn_run[c] >= pw_limit);
      up_run[c] = pd_up[c] ? up_run[c] + 1 : 0;
      dn_run[c] = pd_dn[c] ? dn_run[c] + 1 : 0;
      if (bad) begin good[c] = 0; mlock[c] = 0; end
      else if (cmp_evt[c]) begin
        if (good[c] < lock_count) good[c]++;
        if (good[c] >= lock_count) mlock[c] = 1;
      end
    end
    @(negedge clk);
    check({tag_of(sel), " R11 pin"}, mon_pin, exp_pin);
    check("R7 cnt_rst", cnt_rst, exp_rst);
    check("R8 or R9 chan_locked", chan_locked, {mlock[1], mlock[0]});
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin up_run[c] = 0; dn_run[c] = 0; good[c] = 0; mlock[c] = 0; end
    repeat (3) @(negedge clk);
    check("R1 pin in reset", mon_pin, 0);
    check("R1 cnt_rst in reset", cnt_rst, 0);
    check("R1 lock in reset", chan_locked, 0);
    rst_n = 1'b1;
    repeat (4) tick();                       // R1 idle after release

    // all codes, divider pulses toggling, no lock (R2 R5 R6 R7)
    for (int s = 0; s < 16; s++) begin
      sel = 4'(s);
      for (int k = 0; k < 4; k++) begin
        ref_div = 2'(k); prg_div = 2'(3 - k);
        tick();
      end
    end
    ref_div = '0; prg_div = '0;

    // acquire lock on both channels (R8), pulses at the limit
    for (int p = 0; p < 6; p++) begin
      sel = 4'((p % 3) + 1);
      for (int k = 0; k < 8; k++) begin
        pd_up[0]   = (k < 2);
        pd_dn[1]   = (k < 3);
        cmp_evt[0] = (k == 1);
        cmp_evt[1] = (k == 2);
        tick();
      end
    end
    pd_up = '0; pd_dn = '0; cmp_evt = '0;
    check("R8 both locked", chan_locked, 3);

    // excursion on pin (R10)
    sel = 4'b0010;
    tick();
    check("R10 pin high while locked", mon_pin, 1);
    cmp_evt[0] = 1'b1; tick(); cmp_evt[0] = 1'b0;
    check("R10 one-cycle low excursion", mon_pin, 0);
    tick();
    check("R10 pin back high", mon_pin, 1);

    // over-long pulse on channel 1 with simultaneous event (R9)
    sel = 4'b0011;
    pd_up[0] = 1'b1;
    repeat (3) tick();
    cmp_evt[0] = 1'b1; tick(); cmp_evt[0] = 1'b0;
    pd_up[0] = 1'b0;
    check("R9 channel 1 unlocked", chan_locked[0], 0);
    check("R9 channel 2 kept", chan_locked[1], 1);
    tick();
    check("R4 combined low", mon_pin, 0);

    // random traffic
    lock_count = 6'd3;
    begin
      int left_u[2] = '{0, 0};
      int left_d[2] = '{0, 0};
      for (int n = 0; n < 3000; n++) begin
        if (n % 11 == 0) sel = 4'($urandom % 16);
        for (int c = 0; c < 2; c++) begin
          if (left_u[c] > 0) begin pd_up[c] = 1; left_u[c]--; end
          else begin pd_up[c] = 0; if ($urandom % 9 == 0) left_u[c] = 1 + $urandom % 5; end
          if (left_d[c] > 0) begin pd_dn[c] = 1; left_d[c]--; end
          else begin pd_dn[c] = 0; if ($urandom % 12 == 0) left_d[c] = 1 + $urandom % 4; end
          cmp_evt[c] = ($urandom % 6 == 0);
        end
        ref_div = 2'($urandom); prg_div = 2'($urandom);
        tick();
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule